// File: doc/BRIEF.md
# Width-Switchable Static Memory with Byte Lanes

This block is a synthesizable static memory core. A mode pin chooses how the data bus is organized, and the choice can change from one access to the next. With the mode pin HIGH, the memory is an array of 16-bit words. Two active-low lane enables then mask the lower and upper byte on both reads and writes. With the mode pin LOW, the same storage is seen as an array of bytes that is twice as deep. An extra address bit becomes the least significant address bit, and data moves only on the lower eight pins.

The block is selected only when all of the following are true:
- the active-low chip enable is LOW;
- the active-high chip enable is HIGH;
- at least one lane enable is LOW.

Writes take priority over reads. The three-state data bus is modelled as three vectors: data in, data out, and a per-bit drive enable. All controls are sampled on the rising clock edge. Read data and its drive enable appear one cycle after the read is sampled. The word depth is a parameter, so a simulation can use a small array.

Top module: `dualwidth_sram`

## Requirements
- R1: A cycle is a selected cycle only when `ce_n_i` is 0, `ce_i` is 1 and at least one lane enable is 0. In any other cycle nothing is written, and one cycle later `rdata_oe_o` is all zero.
- R2: A cycle with `lane_lo_n_i` = 1 and `lane_hi_n_i` = 1 is a deselected cycle, even when both chip enables are active. It does not write, and the output is not driven in the next cycle.
- R3: A selected cycle with `oe_n_i` = 0 and `we_n_i` = 1 is a read. The stored data appears on `rdata_o`, with the matching bits of `rdata_oe_o` set, exactly one clock cycle after the read is sampled.
- R4: A cycle with `oe_n_i` = 1 and `we_n_i` = 1 drives nothing, so `rdata_oe_o` is zero in the next cycle.
- R5: A selected cycle with `we_n_i` = 0 is a write, whatever the value of `oe_n_i`. In the next cycle `rdata_oe_o` is zero.
- R6: In word mode (`wide_i` = 1), a write updates bits 7:0 only when `lane_lo_n_i` = 0, and bits 15:8 only when `lane_hi_n_i` = 0. A disabled lane keeps its stored byte.
- R7: In a word-mode read, bits 7:0 of `rdata_oe_o` are set only when `lane_lo_n_i` = 0, and bits 15:8 only when `lane_hi_n_i` = 0. Every bit of `rdata_o` whose drive enable is 0 reads 0.
- R8: In byte mode (`wide_i` = 0), a write stores `wdata_i[7:0]` into word `addr_i`. With `addr_lsb_i` = 0 it goes into bits 7:0 of that word; with `addr_lsb_i` = 1 it goes into bits 15:8. The other byte of the word is unchanged.
- R9: A byte-mode read returns the selected byte on `rdata_o[7:0]`. In the next cycle `rdata_oe_o` is 16'h00FF and `rdata_o[15:8]` is 0.
- R10: In word mode, `addr_lsb_i` has no effect on which word is read or written.
- R11: While `rst_n` is LOW, `rdata_o` and `rdata_oe_o` are zero. Reset does not clear the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| wide_i | input | 1 | Organization: 1 = 16-bit words, 0 = 8-bit bytes |
| addr_i | input | ADDR_W | Word address |
| addr_lsb_i | input | 1 | Byte address LSB in byte mode; ignored in word mode |
| ce_n_i | input | 1 | Active-low chip enable |
| ce_i | input | 1 | Active-high chip enable |
| oe_n_i | input | 1 | Active-low output enable |
| we_n_i | input | 1 | Active-low write enable |
| lane_lo_n_i | input | 1 | Active-low enable for bits 7:0 |
| lane_hi_n_i | input | 1 | Active-low enable for bits 15:8 |
| wdata_i | input | 2*LANE_W | Write data (bus input side) |
| rdata_o | output | 2*LANE_W | Read data (bus output side) |
| rdata_oe_o | output | 2*LANE_W | Per-bit drive enable of the bus |

## Verification
The assertions rely on these properties of the inputs:
- every control and data input holds a known value at each rising edge;
- every address lies inside the configured depth;
- a read is issued only for a word that was written earlier.

The stimulus meets these conditions by changing inputs only on the falling edge, by keeping all addresses below the default depth, and by writing each location before reading it. The same locations are written in one organization and read back in the other, which checks the byte-to-word mapping from both sides.

// File: rtl/dws_pkg.sv
package dws_pkg;
    localparam int LANES = 2;

    typedef struct packed {
        logic [LANES-1:0] wr_lane;   // storage lanes updated this cycle
        logic [LANES-1:0] rd_pins;   // pin lanes to drive next cycle
        logic             byte_mode; // 8-bit organization active
        logic             byte_hi;   // byte mode: upper half addressed
    } dws_cmd_t;
endpackage

// File: rtl/dws_ctrl.sv
module dws_ctrl
    import dws_pkg::*;
(
    input  logic                ce_n_i,
    input  logic                ce_i,
    input  logic                oe_n_i,
    input  logic                we_n_i,
    input  logic [LANES-1:0]    lane_n_i,
    input  logic                wide_i,
    input  logic                addr_lsb_i,
    output dws_cmd_t            cmd_o
);
    logic selected;
    logic do_write;
    logic do_read;

    always_comb begin
        selected = !ce_n_i && ce_i && (lane_n_i != {LANES{1'b1}});
        do_write = selected && !we_n_i;
        do_read  = selected && we_n_i && !oe_n_i;

        cmd_o           = '0;
        cmd_o.byte_mode = !wide_i;
        cmd_o.byte_hi   = !wide_i && addr_lsb_i;

        if (do_write) begin
            if (wide_i) begin
                cmd_o.wr_lane = ~lane_n_i;
            end else begin
                cmd_o.wr_lane = addr_lsb_i ? 2'b10 : 2'b01;
            end
        end

        if (do_read) begin
            cmd_o.rd_pins = wide_i ? ~lane_n_i : 2'b01;
        end
    end
endmodule

// File: rtl/dws_store.sv
module dws_store
    import dws_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 8
) (
    input  logic                      clk,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [LANES-1:0]          wr_lane_i,
    input  logic                      byte_mode_i,
    input  logic [LANES*LANE_W-1:0]   wdata_i,
    output logic [LANES*LANE_W-1:0]   word_o
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];
        logic [LANE_W-1:0] wval;

        // byte mode routes the low pins to whichever lane is addressed
        assign wval = byte_mode_i ? wdata_i[LANE_W-1:0]
                                  : wdata_i[g*LANE_W +: LANE_W];

        always_ff @(posedge clk) begin
            if (wr_lane_i[g]) begin
                mem_q[addr_i] <= wval;
            end
        end

        assign word_o[g*LANE_W +: LANE_W] = mem_q[addr_i];
    end
endmodule

// File: rtl/dualwidth_sram.sv
module dualwidth_sram
    import dws_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wide_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  addr_lsb_i,
    input  logic                  ce_n_i,
    input  logic                  ce_i,
    input  logic                  oe_n_i,
    input  logic                  we_n_i,
    input  logic                  lane_lo_n_i,
    input  logic                  lane_hi_n_i,
    input  logic [2*LANE_W-1:0]   wdata_i,
    output logic [2*LANE_W-1:0]   rdata_o,
    output logic [2*LANE_W-1:0]   rdata_oe_o
);
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] oe;
    } out_t;

    dws_cmd_t          cmd;
    logic [DATA_W-1:0] word;
    out_t              out_d;
    out_t              out_q;

    dws_ctrl i_ctrl (
        .ce_n_i     (ce_n_i),
        .ce_i       (ce_i),
        .oe_n_i     (oe_n_i),
        .we_n_i     (we_n_i),
        .lane_n_i   ({lane_hi_n_i, lane_lo_n_i}),
        .wide_i     (wide_i),
        .addr_lsb_i (addr_lsb_i),
        .cmd_o      (cmd)
    );

    dws_store #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W)
    ) i_store (
        .clk         (clk),
        .addr_i      (addr_i),
        .wr_lane_i   (cmd.wr_lane),
        .byte_mode_i (cmd.byte_mode),
        .wdata_i     (wdata_i),
        .word_o      (word)
    );

    always_comb begin
        out_d = '0;
        for (int l = 0; l < LANES; l++) begin
            if (cmd.rd_pins[l]) begin
                out_d.oe[l*LANE_W +: LANE_W] = '1;
                if (cmd.byte_mode) begin
                    out_d.data[l*LANE_W +: LANE_W] =
                        word[(cmd.byte_hi ? 1 : 0)*LANE_W +: LANE_W];
                end else begin
                    out_d.data[l*LANE_W +: LANE_W] = word[l*LANE_W +: LANE_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rdata_o    = out_q.data;
    assign rdata_oe_o = out_q.oe;

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ce_n_i && ce_i) |=> (rdata_oe_o == '0)); // R1
    AST_NO_LANE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_lo_n_i && lane_hi_n_i) |=> (rdata_oe_o == '0)); // R2
    AST_OE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |=> (rdata_oe_o == '0)); // R4
    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n_i |=> (rdata_oe_o == '0)); // R5
    AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((rdata_o & ~rdata_oe_o) == '0)); // R7
    AST_BYTE_UPPER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_i |=> (rdata_oe_o[DATA_W-1:LANE_W] == '0)); // R9
endmodule

// File: tb/test_dualwidth_sram.sv
module test_dualwidth_sram;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 23;

    typedef struct packed {
        logic        wide;
        logic        lsb;
        logic [5:0]  addr;
        logic        ce_n;
        logic        ce;
        logic        oe_n;
        logic        we_n;
        logic        lo_n;
        logic        hi_n;
        logic [15:0] wd;
        logic [15:0] ed;
        logic [15:0] eoe;
        logic [3:0]  req;
    } vec_t;

    // wide lsb addr ce_n ce oe_n we_n lo_n hi_n wdata exp_data exp_oe req
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,6'd3,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,16'hA1B2,16'h0000,16'h0000,4'd5},  // R5 write
        '{1'b1,1'b0,6'd3,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,16'h0000,16'hA1B2,16'hFFFF,4'd3},  // R3 read
        '{1'b1,1'b0,6'd3,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,16'h0000,16'h0000,16'h0000,4'd6},  // R6 low only
        '{1'b1,1'b0,6'd3,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,16'h0000,16'hA100,16'hFFFF,4'd6},  // R6 upper kept
        '{1'b1,1'b0,6'd3,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,16'h0000,16'hA100,16'hFF00,4'd7},  // R7 upper lane
        '{1'b1,1'b0,6'd3,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,16'h0000,16'h0000,16'h00FF,4'd7},  // R7 lower lane
        '{1'b0,1'b0,6'd5,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,16'h773C,16'h0000,16'h0000,4'd8},  // R8 byte lo
        '{1'b0,1'b1,6'd5,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,16'h55D4,16'h0000,16'h0000,4'd8},  // R8 byte hi
        '{1'b1,1'b0,6'd5,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,16'h0000,16'hD43C,16'hFFFF,4'd8},  // R8 word view
        '{1'b0,1'b1,6'd3,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,16'h0000,16'h00A1,16'h00FF,4'd9},  // R9 upper byte
        '{1'b0,1'b0,6'd5,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,16'h0000,16'h003C,16'h00FF,4'd9},  // R9 lower byte
        '{1'b1,1'b1,6'd7,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,16'h1234,16'h0000,16'h0000,4'd10}, // R10 lsb=1 write
        '{1'b1,1'b0,6'd7,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,16'h0000,16'h1234,16'hFFFF,4'd10}, // R10 lsb=0 read
        '{1'b1,1'b0,6'd3,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,16'h0000,16'h0000,16'h0000,4'd1},  // R1 ce_n high
        '{1'b1,1'b0,6'd3,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,16'hFFFF,16'h0000,16'h0000,4'd1},  // R1 ce low write
        '{1'b1,1'b0,6'd3,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,16'h0000,16'hA100,16'hFFFF,4'd1},  // R1 not written
        '{1'b1,1'b0,6'd3,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,16'hFFFF,16'h0000,16'h0000,4'd2},  // R2 no lanes
        '{1'b1,1'b0,6'd3,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,16'h0000,16'hA100,16'hFFFF,4'd2},  // R2 not written
        '{1'b1,1'b0,6'd3,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,16'h0000,16'h0000,16'h0000,4'd4},  // R4 oe off
        '{1'b1,1'b0,6'd9,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,16'hBEEF,16'h0000,16'h0000,4'd5},  // R5 priority
        '{1'b1,1'b0,6'd9,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,16'h0000,16'hBEEF,16'hFFFF,4'd5},  // R5 stored
        '{1'b0,1'b1,6'd9,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,16'h0011,16'h0000,16'h0000,4'd2},  // R2 byte desel
        '{1'b1,1'b0,6'd9,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,16'h0000,16'hBEEF,16'hFFFF,4'd2}   // R2 unchanged
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_i = 1'b1;
    logic [5:0]  addr_i = '0;
    logic        addr_lsb_i = 1'b0;
    logic        ce_n_i = 1'b1;
    logic        ce_i = 1'b0;
    logic        oe_n_i = 1'b1;
    logic        we_n_i = 1'b1;
    logic        lane_lo_n_i = 1'b1;
    logic        lane_hi_n_i = 1'b1;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o;
    logic [15:0] rdata_oe_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dualwidth_sram i_dualwidth_sram (
        .clk         (clk),
        .rst_n       (rst_n),
        .wide_i      (wide_i),
        .addr_i      (addr_i),
        .addr_lsb_i  (addr_lsb_i),
        .ce_n_i      (ce_n_i),
        .ce_i        (ce_i),
        .oe_n_i      (oe_n_i),
        .we_n_i      (we_n_i),
        .lane_lo_n_i (lane_lo_n_i),
        .lane_hi_n_i (lane_hi_n_i),
        .wdata_i     (wdata_i),
        .rdata_o     (rdata_o),
        .rdata_oe_o  (rdata_oe_o)
    );

    task automatic check(input string tag, input logic [15:0] ed, input logic [15:0] eoe);
        n_checks++;
        if (rdata_o !== ed || rdata_oe_o !== eoe) begin
            n_errors++;
            $display("FAIL %s: data=%h oe=%h expected data=%h oe=%h",
                     tag, rdata_o, rdata_oe_o, ed, eoe);
        end
    endtask

    task automatic apply(input vec_t v);
        wide_i      = v.wide;
        addr_lsb_i  = v.lsb;
        addr_i      = v.addr;
        ce_n_i      = v.ce_n;
        ce_i        = v.ce;
        oe_n_i      = v.oe_n;
        we_n_i      = v.we_n;
        lane_lo_n_i = v.lo_n;
        lane_hi_n_i = v.hi_n;
        wdata_i     = v.wd;
    endtask

    task automatic idle();
        ce_n_i = 1'b1; ce_i = 1'b0; oe_n_i = 1'b1; we_n_i = 1'b1;
    endtask

    initial begin
        // R11: outputs quiet while reset is held
        repeat (2) @(negedge clk);
        check("R11 in reset", 16'h0000, 16'h0000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d vec %0d", VECS[i].req, i), VECS[i].ed, VECS[i].eoe);
        end

        // R3: data lasts only one cycle after the read
        idle();
        @(posedge clk);
        @(negedge clk);
        check("R3 read released", 16'h0000, 16'h0000);

        // R11: reset clears a driven output, contents survive
        apply('{1'b1,1'b0,6'd5,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,16'h0000,16'h0,16'h0,4'd11});
        @(posedge clk);
        @(negedge clk);
        check("R11 before reset", 16'hD43C, 16'hFFFF);
        rst_n = 1'b0;
        #1;
        check("R11 async clear", 16'h0000, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R11 contents kept", 16'hD43C, 16'hFFFF);

        // R8/R9: byte write into a word-written location, read in both views
        apply('{1'b0,1'b1,6'd7,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,16'hFF99,16'h0,16'h0,4'd8});
        @(posedge clk);
        @(negedge clk);
        apply('{1'b1,1'b0,6'd7,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,16'h0000,16'h0,16'h0,4'd8});
        @(posedge clk);
        @(negedge clk);
        check("R8 upper byte replaced", 16'h9934, 16'hFFFF);
        apply('{1'b0,1'b0,6'd7,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,16'h0000,16'h0,16'h0,4'd9});
        @(posedge clk);
        @(negedge clk);
        check("R9 lower byte one lane", 16'h0034, 16'h00FF);

        idle();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule